// File: doc/BRIEF.md
# Program Sequencer with Base-Relative Addressing

This block steps the program counter of a small single-cycle processor and forms the two data addresses each instruction uses. It keeps an 8-bit program counter and an 8-bit base register. Each of the two operand address fields is sent through either as it is or with the base register added, modulo 256. A per-operand select bit makes that choice for each operand on its own. Both effective addresses are combinational outputs, so the data memories can use them in the same cycle.

The instruction stream comes in over a valid/ready handshake. The sequencer takes one instruction in every cycle that `in_valid` is high. `in_ready` is always high, so the block never applies back-pressure. A cycle with `in_valid` low is an idle cycle, and no state changes in it. When an instruction is accepted, the program counter moves to the first effective address if a branch is taken, and to PC+1 otherwise. A branch is taken when any bit of a 4-bit mask matches the flag vector. The branch type chooses whether the mask is compared with the flags or with their inverse. A base-load instruction writes a value supplied by the datapath into the base register. The ALU and the memories are outside this block.

Top module: `prog_sequencer`

## Requirements
- R1: After reset the program counter reads 0 and the base register holds 0, so a base-relative address with field 0 reads 0.
- R2: `ea1` equals `op_a1` + base (mod 256) when `rel1` is 1, and equals `op_a1` when `rel1` is 0, in the same cycle.
- R3: `ea2` equals `op_a2` + base (mod 256) when `rel2` is 1, and equals `op_a2` when `rel2` is 0, without regard to `rel1`.
- R4: An accepted instruction that takes no branch sets the program counter to PC+1 on the next edge, and 255 wraps to 0.
- R5: With `br_kind` = 2'b01 (direct branch), the next PC is `ea1` when any bit of `br_mask & flags` is set. Flags are ordered sign, zero, carry, overflow from bit 3 down to bit 0.
- R6: With `br_kind` = 2'b10 (inverted branch), the next PC is `ea1` when any bit of `br_mask & ~flags` is set, and PC+1 otherwise.
- R7: A zero `br_mask` never takes a branch of either kind. `br_kind` values 2'b00 and 2'b11 never branch.
- R8: The base register takes `bar_wdata` on the edge after an accepted instruction with `bar_load` = 1, and does not change at any other time.
- R9: While `in_valid` is 0, the program counter and the base register hold, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction fields valid; accepted in this cycle |
| in_ready | output | 1 | Always 1; no back-pressure |
| op_a1 | input | 8 | First operand address field |
| op_a2 | input | 8 | Second operand address field |
| rel1 | input | 1 | Add base register to first operand |
| rel2 | input | 1 | Add base register to second operand |
| br_kind | input | 2 | 00 none, 01 direct branch, 10 inverted branch, 11 none |
| br_mask | input | 4 | Branch condition mask |
| flags | input | 4 | Flag vector {S,Z,C,V} |
| bar_load | input | 1 | Write base register from bar_wdata |
| bar_wdata | input | 8 | New base register value |
| ea1 | output | 8 | First effective address / branch target |
| ea2 | output | 8 | Second effective address |
| pc | output | 8 | Current program counter |

## Verification
The clocked properties assume that the instruction fields and `in_valid` are free of X and are stable around the rising edge. The combinational address checks assume that the select bits are known. The stimulus drives every input on the falling edge and keeps each field at a defined value in every cycle, including idle cycles. In idle cycles it puts deliberately hostile values on the branch and base-load inputs, so the hold rule is exercised against real stimulus.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int ADDR_W = 8;
  localparam int FLAG_W = 4;

  typedef enum logic [1:0] {
    BK_NONE = 2'b00,
    BK_DIRECT = 2'b01,
    BK_INVERT = 2'b10,
    BK_RSVD = 2'b11
  } br_kind_e;
endpackage

// File: rtl/seq_ea_gen.sv
module seq_ea_gen #(
  parameter int AW = seq_pkg::ADDR_W
) (
  input  logic [AW-1:0] field,
  input  logic          rel,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] ea
);
  logic [AW-1:0] sum;

  // Modulo-2^AW add: carry out is dropped.
  assign sum = field + base;
  assign ea  = rel ? sum : field;

  always_comb begin
    if (rel == 1'b0) begin
      p_direct_field_r2: assert (ea == field);
    end
  end
endmodule

// File: rtl/seq_branch_eval.sv
module seq_branch_eval #(
  parameter int FW = seq_pkg::FLAG_W
) (
  input  seq_pkg::br_kind_e kind,
  input  logic [FW-1:0]     mask,
  input  logic [FW-1:0]     flags,
  output logic              taken
);
  logic [FW-1:0] sense;

  always_comb begin
    unique case (kind)
      seq_pkg::BK_DIRECT: sense = flags;
      seq_pkg::BK_INVERT: sense = ~flags;
      default:            sense = '0;
    endcase
  end

  assign taken = |(mask & sense);

  always_comb begin
    if (mask == '0) begin
      p_zero_mask_r7: assert (taken == 1'b0);
    end
  end
endmodule

// File: rtl/seq_state.sv
module seq_state #(
  parameter int AW = seq_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          taken,
  input  logic [AW-1:0] target,
  input  logic          bar_we,
  input  logic [AW-1:0] bar_wdata,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] bar
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      bar <= '0;
    end else if (adv) begin
      pc <= taken ? target : pc + ONE;
      if (bar_we) bar <= bar_wdata;
    end
  end

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(pc) && $stable(bar));
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !taken |=> pc == $past(pc) + ONE);
  p_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv && taken |=> pc == $past(target));
  p_bar_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adv && bar_we |=> bar == $past(bar_wdata));
  p_bar_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv && bar_we) |=> $stable(bar));
endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer #(
  parameter int AW = seq_pkg::ADDR_W,
  parameter int FW = seq_pkg::FLAG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] op_a1,
  input  logic [AW-1:0] op_a2,
  input  logic          rel1,
  input  logic          rel2,
  input  logic [1:0]    br_kind,
  input  logic [FW-1:0] br_mask,
  input  logic [FW-1:0] flags,
  input  logic          bar_load,
  input  logic [AW-1:0] bar_wdata,
  output logic [AW-1:0] ea1,
  output logic [AW-1:0] ea2,
  output logic [AW-1:0] pc
);
  localparam int NOPS = 2;

  logic [AW-1:0] base_q;
  logic [AW-1:0] fld [NOPS];
  logic          sel [NOPS];
  logic [AW-1:0] ea  [NOPS];
  logic          take;
  logic          accept;

  assign in_ready = 1'b1;
  assign accept   = in_valid & in_ready;

  assign fld[0] = op_a1;
  assign fld[1] = op_a2;
  assign sel[0] = rel1;
  assign sel[1] = rel2;

  for (genvar i = 0; i < NOPS; i++) begin : g_ea
    seq_ea_gen #(.AW(AW)) u_ea (
      .field(fld[i]),
      .rel  (sel[i]),
      .base (base_q),
      .ea   (ea[i])
    );
  end

  assign ea1 = ea[0];
  assign ea2 = ea[1];

  seq_branch_eval #(.FW(FW)) u_br (
    .kind (seq_pkg::br_kind_e'(br_kind)),
    .mask (br_mask),
    .flags(flags),
    .taken(take)
  );

  seq_state #(.AW(AW)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (accept),
    .taken    (take),
    .target   (ea[0]),
    .bar_we   (bar_load),
    .bar_wdata(bar_wdata),
    .pc       (pc),
    .bar      (base_q)
  );
endmodule

// File: tb/prog_sequencer_test.sv
module prog_sequencer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] op_a1 = '0, op_a2 = '0, bar_wdata = '0;
  logic       rel1 = 1'b0, rel2 = 1'b0, bar_load = 1'b0;
  logic [1:0] br_kind = 2'b00;
  logic [3:0] br_mask = '0, flags = '0;
  logic [7:0] ea1, ea2, pc;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] m_pc = 8'd0;
  logic [7:0] m_bar = 8'd0;

  typedef struct {
    logic [7:0] e1;
    logic [7:0] e2;
    logic [7:0] p;
    string      tag;
  } item_t;
  item_t q[$];
  event  sampled;

  always #2 clk = ~clk;

  prog_sequencer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a1(op_a1), .op_a2(op_a2), .rel1(rel1), .rel2(rel2),
    .br_kind(br_kind), .br_mask(br_mask), .flags(flags),
    .bar_load(bar_load), .bar_wdata(bar_wdata),
    .ea1(ea1), .ea2(ea2), .pc(pc)
  );

  task automatic cmp(input string what, input string tag,
                     input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares against the ports.
  initial begin
    forever begin
      @(sampled);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        cmp("ea1", it.tag, ea1, it.e1);
        cmp("ea2", it.tag, ea2, it.e2);
        cmp("pc", it.tag, pc, it.p);
      end
    end
  end

  // Driver: applies one cycle of stimulus, predicts, then advances the model.
  task automatic step(input string tag, input logic v,
                      input logic [7:0] a1, input logic r1,
                      input logic [7:0] a2, input logic r2,
                      input logic [1:0] k, input logic [3:0] m,
                      input logic [3:0] f, input logic ld,
                      input logic [7:0] wd);
    item_t it;
    logic [7:0] x1, x2;
    logic [3:0] s;
    logic tk;
    @(negedge clk);
    in_valid = v; op_a1 = a1; rel1 = r1; op_a2 = a2; rel2 = r2;
    br_kind = k; br_mask = m; flags = f; bar_load = ld; bar_wdata = wd;
    x1 = r1 ? 8'(a1 + m_bar) : a1;
    x2 = r2 ? 8'(a2 + m_bar) : a2;
    s  = (k == 2'b01) ? f : (k == 2'b10) ? ~f : 4'b0;
    tk = |(m & s);
    #1;
    it.e1 = x1; it.e2 = x2; it.p = m_pc; it.tag = tag;
    q.push_back(it);
    -> sampled;
    if (v) begin
      m_pc = tk ? x1 : 8'(m_pc + 8'd1);
      if (ld) m_bar = wd;
    end
  endtask

  initial begin
    #40000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, base reads as 0
    step("R1", 0, 8'h00, 1, 8'h00, 1, 2'b00, 4'h0, 4'h0, 0, 8'h00);
    // R4: plain steps
    step("R4", 1, 8'h10, 0, 8'h20, 0, 2'b00, 4'hF, 4'hF, 0, 8'h00);
    step("R4", 1, 8'h11, 0, 8'h21, 0, 2'b11, 4'hF, 4'hF, 0, 8'h00);
    // R8: load base 0x30
    step("R8", 1, 8'h00, 0, 8'h00, 0, 2'b00, 4'h0, 4'h0, 1, 8'h30);
    // R2/R3: independent selects, wrap mod 256
    step("R2", 1, 8'h05, 1, 8'h07, 0, 2'b00, 4'h0, 4'h0, 0, 8'h00);
    step("R3", 1, 8'h05, 0, 8'hE0, 1, 2'b00, 4'h0, 4'h0, 0, 8'h00);
    step("R2", 1, 8'hF0, 1, 8'hD0, 1, 2'b00, 4'h0, 4'h0, 0, 8'h00);
    // R5: direct branch on carry (bit1), taken to base-relative target
    step("R5", 1, 8'h10, 1, 8'h00, 0, 2'b01, 4'b0010, 4'b0010, 0, 8'h00);
    step("R5", 1, 8'h80, 0, 8'h00, 0, 2'b01, 4'b1000, 4'b0111, 0, 8'h00);
    step("R5", 1, 8'h90, 0, 8'h00, 0, 2'b01, 4'b1000, 4'b1000, 0, 8'h00);
    // R6: inverted branch
    step("R6", 1, 8'h44, 0, 8'h00, 0, 2'b10, 4'b0100, 4'b0100, 0, 8'h00);
    step("R6", 1, 8'h55, 0, 8'h00, 0, 2'b10, 4'b0100, 4'b1011, 0, 8'h00);
    // R7: zero mask and no-branch kinds
    step("R7", 1, 8'h66, 0, 8'h00, 0, 2'b01, 4'h0, 4'hF, 0, 8'h00);
    step("R7", 1, 8'h66, 0, 8'h00, 0, 2'b10, 4'h0, 4'h0, 0, 8'h00);
    step("R7", 1, 8'h66, 0, 8'h00, 0, 2'b11, 4'hF, 4'h0, 0, 8'h00);
    // R9: idle cycles with hostile inputs
    step("R9", 0, 8'h12, 0, 8'h00, 0, 2'b01, 4'hF, 4'hF, 1, 8'hAA);
    step("R9", 0, 8'h00, 1, 8'h01, 1, 2'b10, 4'hF, 4'h0, 1, 8'h55);
    // R8: base unchanged (still 0x30) seen through relative address
    step("R8", 1, 8'h00, 1, 8'h02, 1, 2'b00, 4'h0, 4'h0, 0, 8'h00);
    // R4: wrap 255 -> 0 after jumping to 0xFF
    step("R4", 1, 8'h00, 0, 8'h00, 0, 2'b00, 4'h0, 4'h0, 1, 8'h00);
    step("R4", 1, 8'hFF, 1, 8'h00, 0, 2'b01, 4'h1, 4'h1, 0, 8'h00);
    step("R4", 1, 8'h00, 0, 8'h00, 0, 2'b00, 4'h0, 4'h0, 0, 8'h00);
    step("R4", 0, 8'h00, 0, 8'h00, 0, 2'b00, 4'h0, 4'h0, 0, 8'h00);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule